// File: doc/BRIEF.md
# Spare-Row Remapping Memory

This block is a synchronous single-port memory that always presents sixteen rows of eight bits to its user. The physical array behind it holds two extra rows that are used only as replacements. A small repair table is filled once, while a configuration input is held high, and then stays fixed in the way blown fuses would. Each table entry names one faulty logical row and the spare row that replaces it. On every access the row address is compared against all valid entries at once. A match sends the read or write to the spare. A miss sends it to the normal row. The user cannot tell which row served the access.

The table has more entries than there are spares, so a test sweep can mark every row it finds faulty. The block compares the number of distinct marked rows against the spare count and raises an unrepairable flag when the marks outnumber the spares. The capacity never shrinks. Two valid entries that name the same row are a configuration error: the entry with the lower index takes effect and an error flag is raised. Only storage rows can be repaired. The decode and port logic have no redundancy.

Top module: `mem_remap_top`

## Requirements
- R1: While rst_n is low at a clock edge, the next dout is 0, every table entry becomes invalid, and config_error and repair_fail read 0.
- R2: With config_mode low, a write (we=1) stores din in the addressed row. dout after each edge holds the row's content as it was before that edge, so a write cycle returns the old value and a read returns the last written value.
- R3: A valid entry {cfg_valid=1, cfg_row=r, cfg_spare=s} sends every access to row r into spare s, where s=0 and s=1 are separate rows. The normal row r keeps its content and shows it again once the entry is made invalid. Rows that no entry names are unaffected.
- R4: While config_mode is high, accesses are ignored: no row is written and dout holds its value.
- R5: A table write (cfg_we=1 at entry cfg_idx) takes effect only while config_mode is high. Outside config mode, cfg_we has no effect on steering or on the flags.
- R6: If two valid entries name the same row, config_error is 1 and the entry with the lower cfg_idx decides the spare. config_error returns to 0 once the duplicate goes away.
- R7: repair_fail is 1 exactly when the number of distinct rows named by valid entries exceeds the spare count (2). Duplicate entries count once.
- R8: Reads have one cycle of latency whether or not the row is remapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| config_mode | input | 1 | High: repair table writable, accesses ignored |
| cfg_we | input | 1 | Repair table entry write strobe |
| cfg_idx | input | 2 | Repair table entry index |
| cfg_valid | input | 1 | Valid bit for the entry being written |
| cfg_row | input | 4 | Faulty logical row for the entry |
| cfg_spare | input | 1 | Spare row index for the entry |
| addr | input | 4 | Logical row address |
| we | input | 1 | Write enable |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| config_error | output | 1 | Two valid entries name the same row |
| repair_fail | output | 1 | More distinct faulty rows than spares |

## Verification
A wrong steering decision shows at dout on the first read after the wrong write. The data comes back from the other physical row: either the spare's content where the normal content was expected, or the reverse. The bench makes this visible by writing distinct patterns to the normal row and to each spare, then making an entry invalid and reading again. A wrong table state shows on config_error or repair_fail in the cycle after the table write. A stray write during config mode shows on the next read of that row once config mode ends.

// File: rtl/remap_pkg.sv
// remap_pkg: geometry and shared types of the spare-row remapping memory.
// Assumes N_SPARE is a power of two so every spare index names a real row.
package remap_pkg;
    parameter int ROW_W     = 4;
    parameter int DATA_W    = 8;
    parameter int N_SPARE   = 2;
    parameter int N_ENTRY   = 4;
    parameter int SP_W      = (N_SPARE > 1) ? $clog2(N_SPARE) : 1;
    parameter int IDX_W     = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;
    parameter int LOG_ROWS  = 1 << ROW_W;
    parameter int PHYS_ROWS = LOG_ROWS + N_SPARE;
    parameter int PHYS_W    = $clog2(PHYS_ROWS);
    parameter int CNT_W     = $clog2(N_ENTRY + 1);
    parameter int ENTRY_W   = 1 + ROW_W + SP_W;

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
        logic [SP_W-1:0]  spare;
    } repair_entry_t;
endpackage

// File: rtl/repair_table.sv
// repair_table: fuse-like table of faulty-row entries with a parallel lookup.
// Entries change only while config_mode is high. The lowest matching index wins.
// It also counts the distinct marked rows to flag an unrepairable part and
// flags entries that name the same row twice.
module repair_table
    import remap_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       config_mode,
    input  logic                       cfg_we,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  repair_entry_t              cfg_entry,
    input  logic [ROW_W-1:0]           lookup_row,
    output logic                       hit,
    output logic [SP_W-1:0]            hit_spare,
    output logic [N_ENTRY-1:0]         valid_vec,
    output logic [N_ENTRY*ENTRY_W-1:0] table_flat,
    output logic                       config_error,
    output logic                       repair_fail
);
    repair_entry_t        tbl [N_ENTRY];
    logic [N_ENTRY-1:0]   first_mark;
    logic [CNT_W-1:0]     distinct_cnt;

    // Purpose: load or clear entries; frozen outside config mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRY; i++) tbl[i] <= '0;
        end else if (config_mode && cfg_we) begin
            tbl[cfg_idx] <= cfg_entry;
        end
    end

    // Purpose: flatten the table for observation by the checker.
    genvar g;
    generate
        for (g = 0; g < N_ENTRY; g++) begin : g_flat
            assign table_flat[g*ENTRY_W +: ENTRY_W] = tbl[g];
            assign valid_vec[g] = tbl[g].valid;
        end
    endgenerate

    // Purpose: parallel compare, scanning high to low so the lowest index wins.
    always_comb begin
        hit       = 1'b0;
        hit_spare = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (tbl[i].valid && (tbl[i].row == lookup_row)) begin
                hit       = 1'b1;
                hit_spare = tbl[i].spare;
            end
        end
    end

    // Purpose: mark each valid entry that is the first to name its row.
    always_comb begin
        for (int i = 0; i < N_ENTRY; i++) begin
            first_mark[i] = tbl[i].valid;
            for (int j = 0; j < i; j++) begin
                if (tbl[j].valid && (tbl[j].row == tbl[i].row))
                    first_mark[i] = 1'b0;
            end
        end
    end

    // Purpose: count distinct faulty rows and derive both flags.
    always_comb begin
        distinct_cnt = '0;
        for (int i = 0; i < N_ENTRY; i++)
            distinct_cnt = distinct_cnt + CNT_W'(first_mark[i]);
        repair_fail  = (distinct_cnt > CNT_W'(N_SPARE));
        config_error = |(valid_vec & ~first_mark);
    end
endmodule

// File: rtl/row_steer.sv
// row_steer: turns a logical row and a lookup result into a physical row.
// Spares sit directly above the logical rows in the raw array.
module row_steer
    import remap_pkg::*;
(
    input  logic              hit,
    input  logic [SP_W-1:0]   hit_spare,
    input  logic [ROW_W-1:0]  row,
    output logic [PHYS_W-1:0] phys_row
);
    // Purpose: choose the spare slot on a hit, else the direct row.
    always_comb begin
        if (hit)
            phys_row = PHYS_W'(LOG_ROWS) + PHYS_W'(hit_spare);
        else
            phys_row = PHYS_W'(row);
    end
endmodule

// File: rtl/row_array.sv
// row_array: raw storage with logical plus spare rows and a registered read.
// The cells are not reset. The read register is reset to zero. A write cycle
// returns the old content.
module row_array
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [PHYS_W-1:0] phys_row,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] cells [PHYS_ROWS];

    // Purpose: store write data into the selected physical row.
    always_ff @(posedge clk) begin
        if (en && we) cells[phys_row] <= din;
    end

    // Purpose: register the selected row's content; hold when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)   dout <= '0;
        else if (en)  dout <= cells[phys_row];
    end
endmodule

// File: rtl/mem_remap_top.sv
// mem_remap_top: fixed-capacity memory whose faulty rows are replaced by spares.
// Assumes the table is programmed in config mode before use. The caller sees
// the same latency and capacity whatever the repair state.
module mem_remap_top
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              config_mode,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [SP_W-1:0]   cfg_spare,
    input  logic [ROW_W-1:0]  addr,
    input  logic              we,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              config_error,
    output logic              repair_fail
);
    repair_entry_t              cfg_entry_w;
    logic                       hit_w;
    logic [SP_W-1:0]            spare_w;
    logic [PHYS_W-1:0]          phys_w;
    logic [N_ENTRY-1:0]         valid_w;
    logic [N_ENTRY*ENTRY_W-1:0] tbl_flat_w;

    // Purpose: pack the programming fields into one entry.
    assign cfg_entry_w = '{valid: cfg_valid, row: cfg_row, spare: cfg_spare};

    repair_table u_table (
        .clk(clk), .rst_n(rst_n), .config_mode(config_mode),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry_w),
        .lookup_row(addr), .hit(hit_w), .hit_spare(spare_w),
        .valid_vec(valid_w), .table_flat(tbl_flat_w),
        .config_error(config_error), .repair_fail(repair_fail)
    );

    row_steer u_steer (
        .hit(hit_w), .hit_spare(spare_w), .row(addr), .phys_row(phys_w)
    );

    row_array u_array (
        .clk(clk), .rst_n(rst_n), .en(!config_mode), .we(we),
        .phys_row(phys_w), .din(din), .dout(dout)
    );
endmodule

// File: rtl/remap_checker.sv
// remap_checker: temporal properties of mem_remap_top, attached by bind.
module remap_checker
    import remap_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       config_mode,
    input logic [ROW_W-1:0]           addr,
    input logic [DATA_W-1:0]          dout,
    input logic                       config_error,
    input logic                       repair_fail,
    input logic                       hit,
    input logic [PHYS_W-1:0]          phys_row,
    input logic [N_ENTRY-1:0]         valid_vec,
    input logic [N_ENTRY*ENTRY_W-1:0] table_flat
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && valid_vec == '0));

    assert_hit_uses_spare_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (phys_row >= PHYS_W'(LOG_ROWS) && phys_row < PHYS_W'(PHYS_ROWS)));

    assert_miss_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (phys_row == PHYS_W'(addr)));

    assert_cfg_holds_dout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        config_mode |=> $stable(dout));

    assert_table_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !config_mode |=> $stable(table_flat));

    assert_dup_needs_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> ($countones(valid_vec) >= 2));

    assert_fail_needs_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        repair_fail |-> ($countones(valid_vec) > N_SPARE));
endmodule

bind mem_remap_top remap_checker u_chk (
    .clk(clk), .rst_n(rst_n), .config_mode(config_mode), .addr(addr),
    .dout(dout), .config_error(config_error), .repair_fail(repair_fail),
    .hit(hit_w), .phys_row(phys_w), .valid_vec(valid_w), .table_flat(tbl_flat_w)
);

// File: tb/sim_mem_remap_top.sv
module sim_mem_remap_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       config_mode = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic       cfg_valid = 1'b0;
    logic [3:0] cfg_row = '0;
    logic [0:0] cfg_spare = '0;
    logic [3:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       config_error, repair_fail;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mem_remap_top u0 (
        .clk(clk), .rst_n(rst_n), .config_mode(config_mode), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_row(cfg_row),
        .cfg_spare(cfg_spare), .addr(addr), .we(we), .din(din), .dout(dout),
        .config_error(config_error), .repair_fail(repair_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One access; returns dout sampled at the negedge after the edge.
    task automatic access(input logic [3:0] a, input logic w,
                          input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        addr = a; we = w; din = d;
        @(negedge clk);
        we = 1'b0;
        q = dout;
    endtask

    task automatic cfg_set(input int idx, input logic v, input logic [3:0] r,
                           input logic s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_valid = v; cfg_row = r; cfg_spare = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        config_mode = m;
    endtask

    task automatic t_reset();
        logic [7:0] q;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 dout after reset", dout, 0);
        chk("R1 config_error after reset", config_error, 0);
        chk("R1 repair_fail after reset", repair_fail, 0);
        rst_n = 1'b1;
        access(4'd2, 1'b1, 8'h22, q);
        access(4'd2, 1'b0, 8'h00, q);
        chk("R1 empty table: row 2 direct", q, 8'h22);
    endtask

    task automatic t_plain();
        logic [7:0] q;
        access(4'd0, 1'b1, 8'h10, q);
        access(4'd15, 1'b1, 8'hF0, q);
        access(4'd5, 1'b1, 8'h5A, q);
        access(4'd5, 1'b1, 8'hC3, q);
        chk("R2 write cycle returns old data", q, 8'h5A);
        access(4'd5, 1'b0, 8'h00, q);
        chk("R2 R8 row 5 readback", q, 8'hC3);
        access(4'd0, 1'b0, 8'h00, q);
        chk("R2 row 0 readback", q, 8'h10);
        access(4'd15, 1'b0, 8'h00, q);
        chk("R2 row 15 readback", q, 8'hF0);
    endtask

    task automatic t_remap();
        logic [7:0] q;
        access(4'd3, 1'b1, 8'h03, q);
        access(4'd12, 1'b1, 8'h0C, q);
        access(4'd4, 1'b1, 8'h44, q);
        set_mode(1'b1);
        cfg_set(0, 1'b1, 4'd3, 1'b0);
        cfg_set(1, 1'b1, 4'd12, 1'b1);
        set_mode(1'b0);
        access(4'd3, 1'b1, 8'hA3, q);
        access(4'd12, 1'b1, 8'hB2, q);
        access(4'd3, 1'b0, 8'h00, q);
        chk("R3 R8 row 3 via spare 0", q, 8'hA3);
        access(4'd12, 1'b0, 8'h00, q);
        chk("R3 R8 row 12 via spare 1", q, 8'hB2);
        access(4'd4, 1'b0, 8'h00, q);
        chk("R3 unmapped row 4 untouched", q, 8'h44);
        set_mode(1'b1);
        cfg_set(0, 1'b0, 4'd3, 1'b0);
        cfg_set(1, 1'b0, 4'd12, 1'b1);
        set_mode(1'b0);
        access(4'd3, 1'b0, 8'h00, q);
        chk("R3 normal row 3 preserved", q, 8'h03);
        access(4'd12, 1'b0, 8'h00, q);
        chk("R3 normal row 12 preserved", q, 8'h0C);
    endtask

    task automatic t_cfgmode();
        logic [7:0] q;
        access(4'd9, 1'b1, 8'h33, q);
        access(4'd9, 1'b0, 8'h00, q);
        set_mode(1'b1);
        access(4'd9, 1'b1, 8'h44, q);
        chk("R4 dout held during config write", q, 8'h33);
        access(4'd0, 1'b0, 8'h00, q);
        chk("R4 dout held during config read", q, 8'h33);
        set_mode(1'b0);
        access(4'd9, 1'b0, 8'h00, q);
        chk("R4 write in config mode ignored", q, 8'h33);
    endtask

    task automatic t_locked();
        logic [7:0] q;
        cfg_set(0, 1'b1, 4'd9, 1'b0);
        cfg_set(1, 1'b1, 4'd9, 1'b1);
        access(4'd9, 1'b0, 8'h00, q);
        chk("R5 table write outside config ignored", q, 8'h33);
        chk("R5 no error from ignored writes", config_error, 0);
    endtask

    task automatic t_dup();
        logic [7:0] q;
        set_mode(1'b1);
        cfg_set(1, 1'b1, 4'd7, 1'b1);
        set_mode(1'b0);
        access(4'd7, 1'b1, 8'h11, q);
        set_mode(1'b1);
        cfg_set(0, 1'b1, 4'd7, 1'b0);
        chk("R6 duplicate raises config_error", config_error, 1);
        set_mode(1'b0);
        access(4'd7, 1'b1, 8'h22, q);
        set_mode(1'b1);
        cfg_set(0, 1'b0, 4'd7, 1'b0);
        chk("R6 config_error clears", config_error, 0);
        set_mode(1'b0);
        access(4'd7, 1'b0, 8'h00, q);
        chk("R6 entry 1 spare untouched by dup write", q, 8'h11);
        set_mode(1'b1);
        cfg_set(0, 1'b1, 4'd7, 1'b0);
        set_mode(1'b0);
        access(4'd7, 1'b0, 8'h00, q);
        chk("R6 lower entry wins", q, 8'h22);
        set_mode(1'b1);
        cfg_set(0, 1'b0, 4'd0, 1'b0);
        cfg_set(1, 1'b0, 4'd0, 1'b0);
        set_mode(1'b0);
    endtask

    task automatic t_fail();
        set_mode(1'b1);
        cfg_set(0, 1'b1, 4'd1, 1'b0);
        cfg_set(1, 1'b1, 4'd2, 1'b1);
        chk("R7 two rows fit two spares", repair_fail, 0);
        cfg_set(2, 1'b1, 4'd4, 1'b0);
        chk("R7 three rows exceed spares", repair_fail, 1);
        cfg_set(2, 1'b1, 4'd1, 1'b0);
        chk("R7 duplicate counted once", repair_fail, 0);
        chk("R6 duplicate entry 2 flagged", config_error, 1);
        cfg_set(3, 1'b1, 4'd8, 1'b1);
        chk("R7 third distinct row via entry 3", repair_fail, 1);
        cfg_set(0, 1'b0, 4'd0, 1'b0);
        cfg_set(1, 1'b0, 4'd0, 1'b0);
        cfg_set(2, 1'b0, 4'd0, 1'b0);
        cfg_set(3, 1'b0, 4'd0, 1'b0);
        chk("R7 cleared table not failing", repair_fail, 0);
        set_mode(1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_remap();
        t_cfgmode();
        t_locked();
        t_dup();
        t_fail();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule